// File: doc/BRIEF.md
# Warp Lane Shuffle Network

This block moves data words between the 32 lanes of one warp in a single registered step. Each lane presents a data word and a small operand. One shared mode chooses how every lane computes the lane it reads from: a direct index, a shift toward higher lane numbers, a shift toward lower lane numbers, or an XOR butterfly. A segment width splits the warp into independent groups of equal size. Lane numbering restarts at zero in each group. A participation mask names the lanes that take part in the exchange.

Where the addressing rules say so, a lane keeps its own word instead of reading another lane. This happens when a shift would leave the lane's segment, or when an XOR source lies in a later segment. A lane outside the mask passes its own word through. A participating lane whose source is outside the mask receives zero and raises its error bit. A width that is not 1, 2, 4, 8, 16 or 32 raises a width error, and every word then passes through unchanged.

The result is registered. A small output state machine has two states. ST_IDLE means no result is presented. ST_HOLD means a fresh result is presented. The ACCEPT transition into ST_HOLD, or from ST_HOLD back to ST_HOLD, is taken on any cycle with in_valid high. The DRAIN transition from ST_HOLD to ST_IDLE is taken on a cycle without in_valid. From ST_IDLE the machine stays in ST_IDLE while in_valid is low.

Top module: `warp_shuffle_xbar`

## Requirements
- R1: out_valid is high in exactly the cycle after a cycle with in_valid high, and low otherwise. After reset, out_valid, out_data, out_src_err and out_width_err are all zero.
- R2: When seg_width is not 1, 2, 4, 8, 16 or 32, out_width_err is 1, every lane's output equals its input word, and out_src_err is zero. For a legal width, out_width_err is 0.
- R3: With shfl_mode 2'b00 (indexed), lane i reads from lane base(i) + (op(i) mod w), where base(i) is i rounded down to a multiple of the width w.
- R4: With shfl_mode 2'b01 (shift up), lane i reads lane i - op(i). When i - op(i) < base(i), lane i keeps its own word.
- R5: With shfl_mode 2'b10 (shift down), lane i reads lane i + op(i). When i + op(i) >= base(i) + w, lane i keeps its own word.
- R6: With shfl_mode 2'b11 (XOR), lane i reads lane i ^ op(i). When that lane lies in a later segment than lane i, lane i keeps its own word. A source in an earlier segment is allowed.
- R7: A lane whose bit in part_mask is 0 outputs its own word, with out_src_err 0 for that lane.
- R8: When a participating lane needs the word of a lane whose part_mask bit is 0, its output word is zero and its out_src_err bit is 1.
- R9: During cycles with in_valid low, out_data and the error outputs keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| shfl_mode | input | 2 | 00 indexed, 01 shift up, 10 shift down, 11 XOR |
| seg_width | input | 6 | Segment width in lanes |
| part_mask | input | 32 | Participation bit per lane |
| lane_data | input | 32*DW | Lane i word at bits [i*DW +: DW] |
| lane_opnd | input | 32*5 | Lane i operand at bits [i*5 +: 5] |
| out_valid | output | 1 | Result present |
| out_data | output | 32*DW | Result words, same packing as lane_data |
| out_src_err | output | 32 | Per-lane flag: source lane not participating |
| out_width_err | output | 1 | Illegal segment width |

## Verification
Each mode is driven with a uniform operand across several segment widths. The runs are chosen so that the keep-own rules fire only on some lanes: shift amounts smaller and larger than the segment, and an indexed operand above the width so that the modulo is visible. XOR masks are chosen to reach both earlier and later segments, which separates the later-segment fallback from a plain same-segment check. Per-lane operands (a reversal and a scattered pattern) show that each lane uses its own operand. Partial masks separate the pass-through of a non-participating lane from the zero-and-flag result of a participating lane whose source does not take part. Back-to-back and idle cycles separate the one-cycle latency from the hold behaviour.

// File: rtl/wsx_pkg.sv
package wsx_pkg;

    typedef enum logic [1:0] {
        SHFL_IDX  = 2'b00,
        SHFL_UP   = 2'b01,
        SHFL_DOWN = 2'b10,
        SHFL_XOR  = 2'b11
    } shfl_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } out_state_e;

endpackage

// File: rtl/wsx_width_decode.sv
module wsx_width_decode #(
    parameter  int LANES = 32,
    localparam int LIDX  = $clog2(LANES),
    localparam int WW    = LIDX + 1
) (
    input  logic [WW-1:0]   seg_width,
    output logic            width_ok,
    output logic [LIDX-1:0] seg_mask
);

    logic [LIDX:0] pow_hit;

    // One comparator for each legal power of two up to the lane count.
    for (genvar k = 0; k <= LIDX; k++) begin : g_pow
        assign pow_hit[k] = (seg_width == WW'(1 << k));
    end

    assign width_ok = |pow_hit;
    // width-1 in the low bits; for the full warp the low bits are zero and wrap to all ones.
    assign seg_mask = seg_width[LIDX-1:0] - LIDX'(1);

endmodule

// File: rtl/wsx_src_sel.sv
module wsx_src_sel
    import wsx_pkg::*;
#(
    parameter  int LANES   = 32,
    parameter  int LANE_ID = 0,
    localparam int LIDX    = $clog2(LANES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chk_en,
    input  shfl_mode_e      mode,
    input  logic [LIDX-1:0] seg_mask,
    input  logic [LIDX-1:0] opnd,
    output logic [LIDX-1:0] src_idx,
    output logic            keep_own
);

    localparam logic [LIDX-1:0] SELF = LIDX'(LANE_ID);

    logic [LIDX-1:0] seg_base;
    logic [LIDX-1:0] rel_pos;
    logic [LIDX:0]   down_reach;
    logic [LIDX-1:0] xor_src;

    assign seg_base   = SELF & ~seg_mask;
    assign rel_pos    = SELF & seg_mask;
    assign down_reach = {1'b0, rel_pos} + {1'b0, opnd};
    assign xor_src    = SELF ^ opnd;

    always_comb begin
        unique case (mode)
            SHFL_IDX: begin
                src_idx  = seg_base | (opnd & seg_mask);
                keep_own = 1'b0;
            end
            SHFL_UP: begin
                src_idx  = SELF - opnd;
                keep_own = (opnd > rel_pos);
            end
            SHFL_DOWN: begin
                src_idx  = SELF + opnd;
                keep_own = (down_reach > {1'b0, seg_mask});
            end
            SHFL_XOR: begin
                src_idx  = xor_src;
                keep_own = ((xor_src & ~seg_mask) > seg_base);
            end
            default: begin
                src_idx  = SELF;
                keep_own = 1'b1;
            end
        endcase
    end

    AST_SHIFT_STAYS_IN_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && !keep_own && (mode == SHFL_UP || mode == SHFL_DOWN || mode == SHFL_IDX))
        |-> ((src_idx & ~seg_mask) == seg_base)); // R4

    AST_XOR_NOT_LATER: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en && !keep_own && mode == SHFL_XOR) |-> ((src_idx & ~seg_mask) <= seg_base)); // R6

endmodule

// File: rtl/wsx_lane_route.sv
module wsx_lane_route #(
    parameter  int LANES   = 32,
    parameter  int DW      = 32,
    parameter  int LANE_ID = 0,
    localparam int LIDX    = $clog2(LANES)
) (
    input  logic [LANES*DW-1:0] lane_data,
    input  logic [LANES-1:0]    part_mask,
    input  logic [LIDX-1:0]     src_idx,
    input  logic                keep_own,
    input  logic                width_ok,
    output logic [DW-1:0]       word_out,
    output logic                src_err
);

    logic [DW-1:0] own_word;
    logic [DW-1:0] far_word;

    assign own_word = lane_data[LANE_ID*DW +: DW];
    assign far_word = lane_data[src_idx*DW +: DW];

    always_comb begin
        word_out = own_word;
        src_err  = 1'b0;
        if (width_ok && part_mask[LANE_ID] && !keep_own) begin
            if (part_mask[src_idx]) begin
                word_out = far_word;
            end else begin
                word_out = '0;
                src_err  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/warp_shuffle_xbar.sv
module warp_shuffle_xbar
    import wsx_pkg::*;
#(
    parameter  int LANES = 32,
    parameter  int DW    = 32,
    localparam int LIDX  = $clog2(LANES),
    localparam int WW    = LIDX + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [1:0]            shfl_mode,
    input  logic [WW-1:0]         seg_width,
    input  logic [LANES-1:0]      part_mask,
    input  logic [LANES*DW-1:0]   lane_data,
    input  logic [LANES*LIDX-1:0] lane_opnd,
    output logic                  out_valid,
    output logic [LANES*DW-1:0]   out_data,
    output logic [LANES-1:0]      out_src_err,
    output logic                  out_width_err
);

    shfl_mode_e      mode;
    logic            width_ok;
    logic [LIDX-1:0] seg_mask;

    logic [LANES*DW-1:0] route_data;
    logic [LANES-1:0]    route_err;

    out_state_e state_q, state_d;

    logic [LANES*DW-1:0] data_q;
    logic [LANES-1:0]    serr_q;
    logic                werr_q;

    assign mode = shfl_mode_e'(shfl_mode);

    wsx_width_decode #(.LANES(LANES)) u_wdec (
        .seg_width (seg_width),
        .width_ok  (width_ok),
        .seg_mask  (seg_mask)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LIDX-1:0] src_idx;
        logic            keep_own;

        wsx_src_sel #(.LANES(LANES), .LANE_ID(g)) u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .chk_en   (in_valid && width_ok),
            .mode     (mode),
            .seg_mask (seg_mask),
            .opnd     (lane_opnd[g*LIDX +: LIDX]),
            .src_idx  (src_idx),
            .keep_own (keep_own)
        );

        wsx_lane_route #(.LANES(LANES), .DW(DW), .LANE_ID(g)) u_route (
            .lane_data (lane_data),
            .part_mask (part_mask),
            .src_idx   (src_idx),
            .keep_own  (keep_own),
            .width_ok  (width_ok),
            .word_out  (route_data[g*DW +: DW]),
            .src_err   (route_err[g])
        );

        AST_ERR_MEANS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            out_src_err[g] |-> (out_data[g*DW +: DW] == '0)); // R8

        AST_IDLE_LANE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !part_mask[g]) |=>
            ((out_data[g*DW +: DW] == $past(lane_data[g*DW +: DW])) && !out_src_err[g])); // R7
    end

    // Output state machine: state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: ACCEPT on in_valid, DRAIN otherwise.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = in_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Result capture on each accepted request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            serr_q <= '0;
            werr_q <= 1'b0;
        end else if (in_valid) begin
            data_q <= route_data;
            serr_q <= route_err;
            werr_q <= !width_ok;
        end
    end

    // Output process.
    always_comb begin
        out_valid     = (state_q == ST_HOLD);
        out_data      = data_q;
        out_src_err   = serr_q;
        out_width_err = werr_q;
    end

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1

    AST_BAD_WIDTH_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !width_ok) |=>
        (out_width_err && (out_data == $past(lane_data)) && (out_src_err == '0))); // R2

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_src_err) && $stable(out_width_err))); // R9

endmodule

// File: tb/warp_shuffle_xbar_tb.sv
module warp_shuffle_xbar_tb;

    localparam int LANES = 32;
    localparam int DW    = 32;
    localparam int LIDX  = 5;
    localparam int NVEC  = 16;

    // Vector layout: {mode[1:0], width[5:0], mask[31:0], op[4:0]}
    localparam logic [44:0] VEC [NVEC] = '{
        {2'd0, 6'd32, 32'hFFFF_FFFF, 5'd7 },  // R3 indexed, full warp
        {2'd0, 6'd8,  32'hFFFF_FFFF, 5'd13},  // R3 indexed, op mod 8 = 5
        {2'd1, 6'd32, 32'hFFFF_FFFF, 5'd3 },  // R4 shift up
        {2'd1, 6'd8,  32'hFFFF_FFFF, 5'd5 },  // R4 shift up inside 8-lane groups
        {2'd2, 6'd32, 32'hFFFF_FFFF, 5'd4 },  // R5 shift down
        {2'd2, 6'd16, 32'hFFFF_FFFF, 5'd9 },  // R5 shift down inside 16-lane groups
        {2'd3, 6'd32, 32'hFFFF_FFFF, 5'd1 },  // R6 xor neighbour
        {2'd3, 6'd8,  32'hFFFF_FFFF, 5'd16},  // R6 later segment keeps own, earlier allowed
        {2'd3, 6'd4,  32'hFFFF_FFFF, 5'd2 },  // R6 xor inside 4-lane groups
        {2'd1, 6'd1,  32'hFFFF_FFFF, 5'd1 },  // R4 width 1, every lane keeps own
        {2'd0, 6'd16, 32'h0000_FFFF, 5'd3 },  // R7 upper lanes not participating
        {2'd2, 6'd32, 32'h5555_5555, 5'd1 },  // R8 even lanes read odd non-participants
        {2'd0, 6'd3,  32'hFFFF_FFFF, 5'd1 },  // R2 width not a power of two
        {2'd2, 6'd48, 32'hFFFF_FFFF, 5'd1 },  // R2 width too large
        {2'd3, 6'd0,  32'hFFFF_FFFF, 5'd1 },  // R2 width zero
        {2'd3, 6'd32, 32'hFFFF_FFFF, 5'd31}   // R6 full reversal by xor
    };

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic [1:0]            shfl_mode = '0;
    logic [5:0]            seg_width = 6'd32;
    logic [LANES-1:0]      part_mask = '0;
    logic [LANES*DW-1:0]   lane_data = '0;
    logic [LANES*LIDX-1:0] lane_opnd = '0;
    logic                  out_valid;
    logic [LANES*DW-1:0]   out_data;
    logic [LANES-1:0]      out_src_err;
    logic                  out_width_err;

    logic [LANES*DW-1:0] exp_data;
    logic [LANES-1:0]    exp_serr;
    logic                exp_werr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    warp_shuffle_xbar #(.LANES(LANES), .DW(DW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .shfl_mode     (shfl_mode),
        .seg_width     (seg_width),
        .part_mask     (part_mask),
        .lane_data     (lane_data),
        .lane_opnd     (lane_opnd),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .out_src_err   (out_src_err),
        .out_width_err (out_width_err)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic check_vec(string req, logic [LANES*DW-1:0] act, logic [LANES*DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model written from the requirement text.
    task automatic model();
        int w;
        bit ok;
        w  = int'(seg_width);
        ok = (w == 1 || w == 2 || w == 4 || w == 8 || w == 16 || w == 32);
        exp_werr = !ok;
        exp_serr = '0;
        for (int i = 0; i < LANES; i++) begin
            int  op, src, base;
            bit  keep;
            op   = int'(lane_opnd[i*LIDX +: LIDX]);
            exp_data[i*DW +: DW] = lane_data[i*DW +: DW];
            if (ok && part_mask[i]) begin
                base = (i / w) * w;
                keep = 1'b0;
                src  = i;
                case (shfl_mode)
                    2'd0: src = base + (op % w);
                    2'd1: begin src = i - op; keep = (src < base);     end
                    2'd2: begin src = i + op; keep = (src >= base + w); end
                    default: begin src = i ^ op; keep = ((src / w) > (i / w)); end
                endcase
                if (!keep) begin
                    if (part_mask[src]) begin
                        exp_data[i*DW +: DW] = lane_data[src*DW +: DW];
                    end else begin
                        exp_data[i*DW +: DW] = '0;
                        exp_serr[i] = 1'b1;
                    end
                end
            end
        end
    endtask

    task automatic fill_data(int seed);
        for (int i = 0; i < LANES; i++) begin
            lane_data[i*DW +: DW] = (32'(seed) << 24) | 32'h0080_0000 | (32'(i) * 32'h0101) | 32'h1;
        end
    endtask

    task automatic fill_opnd(logic [4:0] op);
        for (int i = 0; i < LANES; i++) lane_opnd[i*LIDX +: LIDX] = op;
    endtask

    task automatic check_result(string req);
        check_vec({req, " out_valid"}, {{(LANES*DW-1){1'b0}}, out_valid}, {{(LANES*DW-1){1'b0}}, 1'b1});
        check_vec({req, " out_data"}, out_data, exp_data);
        check_vec({req, " out_src_err"}, {{(LANES*DW-LANES){1'b0}}, out_src_err},
                  {{(LANES*DW-LANES){1'b0}}, exp_serr});
        check_vec({req, " out_width_err"}, {{(LANES*DW-1){1'b0}}, out_width_err},
                  {{(LANES*DW-1){1'b0}}, exp_werr});
    endtask

    // Drive one request at a falling edge, check one cycle later.
    task automatic run_one(string req);
        model();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_result(req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_vec("R1 reset out_valid", {{(LANES*DW-1){1'b0}}, out_valid}, '0);
        check_vec("R1 reset out_data", out_data, '0);
        check_vec("R1 reset errors", {{(LANES*DW-LANES-1){1'b0}}, out_width_err, out_src_err}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            shfl_mode = VEC[v][44:43];
            seg_width = VEC[v][42:37];
            part_mask = VEC[v][36:5];
            fill_opnd(VEC[v][4:0]);
            fill_data(v + 1);
            run_one($sformatf("R1-table vector %0d mode %0d", v, VEC[v][44:43]));
        end

        // R3 per-lane operands: reversal across the full warp
        shfl_mode = 2'd0; seg_width = 6'd32; part_mask = '1; fill_data(40);
        for (int i = 0; i < LANES; i++) lane_opnd[i*LIDX +: LIDX] = 5'(31 - i);
        run_one("R3 per-lane reversal");

        // R3 scattered per-lane operands in 8-lane groups
        seg_width = 6'd8; fill_data(41);
        for (int i = 0; i < LANES; i++) lane_opnd[i*LIDX +: LIDX] = 5'((i * 7 + 3) % 32);
        run_one("R3 per-lane scatter");

        // R5 and R8: shift down with a mask hole inside the reach
        shfl_mode = 2'd2; seg_width = 6'd16; part_mask = 32'hFFFF_FEFF; fill_opnd(5'd2);
        fill_data(42);
        run_one("R8 shift down into hole");

        // R1 back-to-back requests, then R9 hold while idle
        shfl_mode = 2'd1; seg_width = 6'd4; part_mask = '1; fill_opnd(5'd1); fill_data(43);
        model();
        in_valid = 1'b1;
        @(negedge clk);
        check_result("R1 back-to-back first");
        shfl_mode = 2'd3; seg_width = 6'd16; fill_opnd(5'd20); fill_data(44);
        model();
        @(negedge clk);
        in_valid = 1'b0;
        check_result("R1 back-to-back second");
        // R9: inputs change with in_valid low; outputs must hold
        shfl_mode = 2'd0; seg_width = 6'd5; part_mask = 32'h0F0F_0F0F; fill_data(45); fill_opnd(5'd9);
        @(negedge clk);
        check_vec("R1 out_valid drops", {{(LANES*DW-1){1'b0}}, out_valid}, '0);
        check_vec("R9 data held", out_data, exp_data);
        check_vec("R9 errors held", {{(LANES*DW-LANES-1){1'b0}}, out_width_err, out_src_err},
                  {{(LANES*DW-LANES-1){1'b0}}, exp_werr, exp_serr});
        repeat (2) @(negedge clk);
        check_vec("R9 data held longer", out_data, exp_data);

        // R7 with every lane masked off: all lanes pass through, no errors
        shfl_mode = 2'd2; seg_width = 6'd32; part_mask = '0; fill_opnd(5'd1); fill_data(46);
        run_one("R7 empty mask");

        finish_run();
    end

endmodule